// File: doc/BRIEF.md
# Load/Store Lane Alignment Unit

This unit sits between the execute stage of a 32-bit core and a byte-addressed data memory that is 32 bits wide. For each access it adds a base register to a sign-extended 16-bit displacement to form the effective address. It presents the word-aligned address to memory. For stores it produces the byte-enable mask and lane-replicated write data. For loads it later picks the addressed byte or halfword out of the returned word and sign- or zero-extends it.

Accesses whose width does not fit the low address bits are reported on a misalignment output in the request cycle. Such an access reaches memory neither as a write nor as a read. The memory is assumed to be synchronous: read data for a request appears one clock after the request. The unit holds the lane and extension details of an outstanding load for that one cycle.

Top module: `lane_align_unit`

## Requirements
- R1: The effective address is `base` plus `offset` sign-extended to 32 bits, wrapping modulo 2^32. `mem_addr` carries it with bits 1:0 forced to zero, in the same cycle as the request.
- R2: Width code `req_size` 00 means byte. A valid, aligned byte store sets only `mem_be` bit N, where N = address bits 1:0 and lane N is data bits 8N+7:8N. It drives the source's low byte on all four lanes of `mem_wdata`.
- R3: Width code 01 means halfword. A valid, aligned halfword store sets `mem_be` to 0011 when address bit 1 is 0 and to 1100 when it is 1. It drives the source's low 16 bits on both halves of `mem_wdata`.
- R4: Width codes 10 and 11 both mean word. A valid, aligned word store sets `mem_be` to 1111 and passes all 32 source bits to `mem_wdata` unchanged. `mem_we` is high exactly when `mem_be` is nonzero.
- R5: A valid halfword access with address bit 0 set, or a valid word access with address bits 1:0 nonzero, raises `misalign` in the request cycle. It then holds `mem_be`, `mem_we` and `mem_re` low, and no load result follows.
- R6: While `req_valid` is low, `misalign`, `mem_we`, `mem_re` and `mem_be` are all zero, whatever the other request inputs are.
- R7: A valid, aligned load raises `mem_re` in its request cycle. One cycle later `load_valid` is high and `load_data` is formed from `mem_rdata` in that cycle.
- R8: Byte loads return the byte in lane (address bits 1:0). With `req_unsigned` = 0, bit 7 is copied into bits 31:8. With `req_unsigned` = 1, bits 31:8 are zero.
- R9: Halfword loads return bits 31:16 of the word when address bit 1 is 1, else bits 15:0. The value is extended as in R8, from bit 15.
- R10: Word loads return all 32 bits of `mem_rdata` unchanged.
- R11: `load_data` is zero in every cycle in which `load_valid` is low.
- R12: While `rst_n` is low, `load_valid` is low. A load presented in a cycle that ends in reset produces no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | An access is presented this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_unsigned | input | 1 | Load extension: 1 = zero-extend, 0 = sign-extend |
| base | input | 32 | Base register value |
| offset | input | 16 | Two's-complement displacement |
| store_data | input | 32 | Store source register |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane write enables |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Word returned by memory one cycle after the read |
| misalign | output | 1 | Access rejected for alignment |
| load_valid | output | 1 | `load_data` holds a load result |
| load_data | output | 32 | Extended load result |

## Verification
Address, byte enables, write data, strobes and the misalignment flag are combinational from the request and are due in the request cycle itself. The load result passes through one register stage plus the memory's read register, so it is due exactly one cycle later. The bench changes the request on a falling edge and samples the request-cycle outputs a moment later. It then waits one more falling edge and samples `load_valid` and `load_data`, with the request already withdrawn. Because of that, a result cannot be attributed to the wrong request.

// File: rtl/lsa_pkg.sv
// Shared types for the load/store lane alignment unit.
// Assumes a 32-bit data path split into four byte lanes, little-endian.
package lsa_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    // Access width code as presented by the execute stage.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    // Details of an outstanding load, kept for the data return cycle.
    typedef struct packed {
        logic [LANE_W-1:0] lane;
        acc_size_e         size;
        logic              zext;
    } ld_info_t;

endpackage

// File: rtl/lsa_agen.sv
// Effective address generator: base plus a sign-extended displacement.
// Assumes OFS_W <= ADDR_W; the sum wraps modulo 2^ADDR_W.
module lsa_agen #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFS_W-1:0]  offset,
    output logic [ADDR_W-1:0] eff_addr
);

    localparam int EXT_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] ofs_ext;

    // Sign-extend the displacement to address width.
    always_comb begin
        ofs_ext = {{EXT_W{offset[OFS_W-1]}}, offset};
    end

    // Modular add of base and extended displacement.
    always_comb begin
        eff_addr = base + ofs_ext;
    end

endmodule

// File: rtl/lsa_store_steer.sv
// Store-side lane steering and alignment check.
// Produces the byte-enable mask, replicates the source data across lanes
// so that every enabled lane carries the right byte, and flags accesses
// whose width does not fit the low address bits. Assumes four lanes.
module lsa_store_steer
    import lsa_pkg::*;
(
    input  logic              valid,
    input  logic              store,
    input  acc_size_e         size,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] src,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata,
    output logic              misalign
);

    logic             bad_align;
    logic [LANES-1:0] mask;

    // Alignment rule per width: halfword needs bit 0 clear, word needs both clear.
    always_comb begin
        case (size)
            SZ_BYTE: bad_align = 1'b0;
            SZ_HALF: bad_align = lane[0];
            default: bad_align = |lane;
        endcase
    end

    // Lanes touched by the access, before gating.
    always_comb begin
        case (size)
            SZ_BYTE: mask = LANES'(1) << lane;
            SZ_HALF: mask = lane[1] ? 4'b1100 : 4'b0011;
            default: mask = '1;
        endcase
    end

    // Gate the flag and the enables with the request qualifiers.
    always_comb begin
        misalign = valid & bad_align;
        be       = (valid & store & ~bad_align) ? mask : '0;
    end

    // Per-lane data replication.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_byte;

        // Choose the source byte this lane carries for the current width.
        always_comb begin
            case (size)
                SZ_BYTE: lane_byte = src[7:0];
                SZ_HALF: lane_byte = src[8*(g%2) +: 8];
                default: lane_byte = src[8*g +: 8];
            endcase
        end

        assign wdata[8*g +: 8] = lane_byte;
    end

endmodule

// File: rtl/lsa_load_extract.sv
// Load-side lane selection and extension.
// Picks the addressed byte or halfword from the returned word and
// extends it to full width; outputs zero when no result is due.
module lsa_load_extract
    import lsa_pkg::*;
(
    input  logic              valid,
    input  ld_info_t          info,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] data
);

    logic [7:0]  byte_pick;
    logic [15:0] half_pick;
    logic        fill;

    // Byte lane multiplexer driven by the saved lane number.
    always_comb begin
        byte_pick = '0;
        for (int i = 0; i < LANES; i++) begin
            if (info.lane == i[LANE_W-1:0]) begin
                byte_pick = rdata[8*i +: 8];
            end
        end
    end

    // Halfword selection by the upper lane bit.
    always_comb begin
        half_pick = info.lane[1] ? rdata[31:16] : rdata[15:0];
    end

    // Fill bit for the upper part: the sign bit, or zero for unsigned loads.
    always_comb begin
        case (info.size)
            SZ_BYTE: fill = ~info.zext & byte_pick[7];
            SZ_HALF: fill = ~info.zext & half_pick[15];
            default: fill = 1'b0;
        endcase
    end

    // Assemble the extended result.
    always_comb begin
        if (!valid) begin
            data = '0;
        end else begin
            case (info.size)
                SZ_BYTE: data = {{(DATA_W-8){fill}}, byte_pick};
                SZ_HALF: data = {{(DATA_W-16){fill}}, half_pick};
                default: data = rdata;
            endcase
        end
    end

endmodule

// File: rtl/lane_align_unit.sv
// Top of the load/store lane alignment unit.
// Request-side outputs are combinational. A load result is due one
// cycle after its request, matching a synchronous memory read.
// Assumes the memory registers mem_rdata on the edge that ends the request.
module lane_align_unit
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [ADDR_W-1:0] base,
    input  logic [OFS_W-1:0]  offset,
    input  logic [DATA_W-1:0] store_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              misalign,
    output logic              load_valid,
    output logic [DATA_W-1:0] load_data
);

    logic [ADDR_W-1:0] eff_addr;
    acc_size_e         size_code;
    ld_info_t          info_q;
    logic              ld_pend_q;

    assign size_code = acc_size_e'(req_size);

    lsa_agen #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W)
    ) u_agen (
        .base     (base),
        .offset   (offset),
        .eff_addr (eff_addr)
    );

    lsa_store_steer u_steer (
        .valid    (req_valid),
        .store    (req_store),
        .size     (size_code),
        .lane     (eff_addr[LANE_W-1:0]),
        .src      (store_data),
        .be       (mem_be),
        .wdata    (mem_wdata),
        .misalign (misalign)
    );

    // Memory-facing address and strobes.
    always_comb begin
        mem_addr = {eff_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
        mem_we   = |mem_be;
        mem_re   = req_valid & ~req_store & ~misalign;
    end

    // Hold the lane and extension of a read for its data return cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_pend_q <= 1'b0;
            info_q    <= '0;
        end else begin
            ld_pend_q <= mem_re;
            if (mem_re) begin
                info_q <= '{lane: eff_addr[LANE_W-1:0], size: size_code, zext: req_unsigned};
            end
        end
    end

    lsa_load_extract u_extract (
        .valid (ld_pend_q),
        .info  (info_q),
        .rdata (mem_rdata),
        .data  (load_data)
    );

    assign load_valid = ld_pend_q;

endmodule

// File: rtl/lsa_checker.sv
// Protocol checks for lane_align_unit, attached by bind.
// Observes ports only; every property is disabled while reset is low.
module lsa_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_store,
    input logic [3:0]  mem_be,
    input logic        mem_we,
    input logic        mem_re,
    input logic [31:0] mem_wdata,
    input logic        misalign,
    input logic        load_valid,
    input logic [31:0] load_data
);

    // R6: a write needs a valid store request.
    a_r6_write_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (req_valid && req_store));

    // R5: a flagged access reaches memory in neither direction.
    a_r5_misalign_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_we && !mem_re));

    // R4: enable masks are one, two or four lanes wide.
    a_r4_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

    // R2: a single-lane write carries the same byte on every lane.
    a_r2_byte_replicated: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $countones(mem_be) == 1) |->
        (mem_wdata[7:0] == mem_wdata[15:8] && mem_wdata[7:0] == mem_wdata[23:16]
         && mem_wdata[7:0] == mem_wdata[31:24]));

    // R3: a two-lane write carries the same halfword in both halves.
    a_r3_half_replicated: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $countones(mem_be) == 2) |-> (mem_wdata[15:0] == mem_wdata[31:16]));

    // R7: a read is answered in the next cycle.
    a_r7_result_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> load_valid);

    // R7: no result without a read in the previous cycle.
    a_r7_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_re |=> !load_valid);

    // R11: idle result bus is zero.
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !load_valid |-> (load_data == 32'h0));

endmodule

bind lane_align_unit lsa_checker u_chk (.*);

// File: tb/sim_lane_align_unit.sv
module sim_lane_align_unit;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        st;
        logic [1:0]  sz;
        logic        uns;
        logic [31:0] base;
        logic [15:0] ofs;
        logic [31:0] sdata;
        logic [3:0]  be;
        logic [31:0] wd;
        logic        mis;
        logic [31:0] ld;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'b10, 1'b0, 32'h100, 16'h0000, 32'h8899AABB, 4'hF, 32'h8899AABB, 1'b0, 32'h0},
        '{1'b1, 2'b00, 1'b0, 32'h010, 16'hFFF4, 32'h123456F0, 4'h1, 32'hF0F0F0F0, 1'b0, 32'h0},
        '{1'b1, 2'b00, 1'b0, 32'h007, 16'h0000, 32'h00000081, 4'h8, 32'h81818181, 1'b0, 32'h0},
        '{1'b1, 2'b01, 1'b0, 32'h008, 16'h0000, 32'hDEADC355, 4'h3, 32'hC355C355, 1'b0, 32'h0},
        '{1'b1, 2'b01, 1'b0, 32'h008, 16'h0001, 32'h0000BEEF, 4'h0, 32'hBEEFBEEF, 1'b1, 32'h0},
        '{1'b1, 2'b10, 1'b0, 32'h00C, 16'h0002, 32'h11111111, 4'h0, 32'h11111111, 1'b1, 32'h0},
        '{1'b1, 2'b01, 1'b0, 32'h00C, 16'h0002, 32'h00007FAB, 4'hC, 32'h7FAB7FAB, 1'b0, 32'h0},
        '{1'b1, 2'b11, 1'b0, 32'h010, 16'h0000, 32'hCAFEF00D, 4'hF, 32'hCAFEF00D, 1'b0, 32'h0},
        '{1'b0, 2'b00, 1'b0, 32'h007, 16'h0000, 32'h0, 4'h0, 32'h0, 1'b0, 32'hFFFFFF81},
        '{1'b0, 2'b00, 1'b1, 32'h007, 16'h0000, 32'h0, 4'h0, 32'h0, 1'b0, 32'h00000081},
        '{1'b0, 2'b00, 1'b0, 32'h004, 16'h0000, 32'h0, 4'h0, 32'h0, 1'b0, 32'hFFFFFFF0},
        '{1'b0, 2'b00, 1'b1, 32'h005, 16'h0000, 32'h0, 4'h0, 32'h0, 1'b0, 32'h00000000},
        '{1'b0, 2'b01, 1'b0, 32'h008, 16'h0000, 32'h0, 4'h0, 32'h0, 1'b0, 32'hFFFFC355},
        '{1'b0, 2'b01, 1'b1, 32'h008, 16'h0000, 32'h0, 4'h0, 32'h0, 1'b0, 32'h0000C355},
        '{1'b0, 2'b01, 1'b0, 32'h100, 16'h0002, 32'h0, 4'h0, 32'h0, 1'b0, 32'hFFFF8899},
        '{1'b0, 2'b01, 1'b1, 32'h100, 16'h0002, 32'h0, 4'h0, 32'h0, 1'b0, 32'h00008899},
        '{1'b0, 2'b10, 1'b0, 32'h200, 16'hFF00, 32'h0, 4'h0, 32'h0, 1'b0, 32'h8899AABB},
        '{1'b0, 2'b00, 1'b0, 32'h101, 16'h0000, 32'h0, 4'h0, 32'h0, 1'b0, 32'hFFFFFFAA},
        '{1'b0, 2'b00, 1'b1, 32'h102, 16'h0000, 32'h0, 4'h0, 32'h0, 1'b0, 32'h00000099},
        '{1'b0, 2'b01, 1'b0, 32'h00C, 16'h0002, 32'h0, 4'h0, 32'h0, 1'b0, 32'h00007FAB},
        '{1'b0, 2'b01, 1'b0, 32'h103, 16'h0000, 32'h0, 4'h0, 32'h0, 1'b1, 32'h0},
        '{1'b0, 2'b10, 1'b0, 32'h102, 16'h0000, 32'h0, 4'h0, 32'h0, 1'b1, 32'h0},
        '{1'b0, 2'b11, 1'b0, 32'h010, 16'h0000, 32'h0, 4'h0, 32'h0, 1'b0, 32'hCAFEF00D},
        '{1'b0, 2'b00, 1'b0, 32'h00E, 16'h0001, 32'h0, 4'h0, 32'h0, 1'b0, 32'h0000007F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_unsigned = 1'b0;
    logic [31:0] base = '0;
    logic [15:0] offset = '0;
    logic [31:0] store_data = '0;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic        mem_we;
    logic        mem_re;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        misalign;
    logic        load_valid;
    logic [31:0] load_data;

    logic [31:0] mem [16];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    lane_align_unit u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_store    (req_store),
        .req_size     (req_size),
        .req_unsigned (req_unsigned),
        .base         (base),
        .offset       (offset),
        .store_data   (store_data),
        .mem_addr     (mem_addr),
        .mem_be       (mem_be),
        .mem_we       (mem_we),
        .mem_re       (mem_re),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .misalign     (misalign),
        .load_valid   (load_valid),
        .load_data    (load_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Synchronous byte-enabled memory model with a one-cycle read.
    always @(posedge clk) begin
        for (int b = 0; b < 4; b++) begin
            if (mem_we && mem_be[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
        if (mem_re) mem_rdata <= mem[mem_addr[5:2]];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string size_tag(input logic [1:0] sz, input logic st);
        if (sz == 2'b00) return st ? "R2" : "R8";
        if (sz == 2'b01) return st ? "R3" : "R9";
        return st ? "R4" : "R10";
    endfunction

    task automatic drive(input logic v, input logic st, input logic [1:0] sz, input logic u,
                         input logic [31:0] b, input logic [15:0] o, input logic [31:0] d);
        req_valid = v; req_store = st; req_size = sz; req_unsigned = u;
        base = b; offset = o; store_data = d;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;

        // R12: load presented during reset yields no result.
        @(negedge clk);
        drive(1'b1, 1'b0, 2'b10, 1'b0, 32'h100, 16'h0, 32'h0);
        @(negedge clk); #1;
        check("R12 load_valid in reset", {31'b0, load_valid}, 32'h0);
        check("R11 load_data in reset", load_data, 32'h0);
        drive(1'b0, 1'b0, 2'b00, 1'b0, 32'h0, 16'h0, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table: request-cycle outputs, then the result one cycle later.
        for (int i = 0; i < NV; i++) begin
            logic [31:0] ea;
            @(negedge clk);
            drive(1'b1, VEC[i].st, VEC[i].sz, VEC[i].uns, VEC[i].base, VEC[i].ofs, VEC[i].sdata);
            ea = VEC[i].base + {{16{VEC[i].ofs[15]}}, VEC[i].ofs};
            #1;
            check("R1 mem_addr", mem_addr, {ea[31:2], 2'b00});
            check("R5 misalign", {31'b0, misalign}, {31'b0, VEC[i].mis});
            if (VEC[i].st) begin
                check({size_tag(VEC[i].sz, 1'b1), " mem_be"}, {28'b0, mem_be}, {28'b0, VEC[i].be});
                check({size_tag(VEC[i].sz, 1'b1), " mem_wdata"}, mem_wdata, VEC[i].wd);
                check("R4 mem_we", {31'b0, mem_we}, {31'b0, |VEC[i].be});
            end else begin
                check("R7 mem_re", {31'b0, mem_re}, {31'b0, ~VEC[i].mis});
                check("R5 load mem_be", {28'b0, mem_be}, 32'h0);
            end
            @(negedge clk);
            drive(1'b0, 1'b0, 2'b00, 1'b0, 32'h0, 16'h0, 32'h0);
            #1;
            if (!VEC[i].st) begin
                if (VEC[i].mis) begin
                    check("R5 no result", {31'b0, load_valid}, 32'h0);
                end else begin
                    check("R7 load_valid", {31'b0, load_valid}, 32'h1);
                    check({size_tag(VEC[i].sz, 1'b0), " load_data"}, load_data, VEC[i].ld);
                end
            end
        end

        // R11: after a result, the idle cycle returns zero though memory data is held.
        @(negedge clk); #1;
        check("R11 idle load_data", load_data, 32'h0);

        // R6: requests ignored while req_valid is low, even misaligned ones.
        drive(1'b0, 1'b1, 2'b10, 1'b0, 32'h0, 16'h0, 32'hFFFFFFFF);
        #1;
        check("R6 mem_be", {28'b0, mem_be}, 32'h0);
        check("R6 mem_we", {31'b0, mem_we}, 32'h0);
        drive(1'b0, 1'b0, 2'b10, 1'b0, 32'h3, 16'h0, 32'h0);
        #1;
        check("R6 misalign", {31'b0, misalign}, 32'h0);
        check("R6 mem_re", {31'b0, mem_re}, 32'h0);

        // R1: address wraps modulo 2^32.
        drive(1'b1, 1'b0, 2'b00, 1'b0, 32'hFFFFFFFE, 16'h0004, 32'h0);
        #1;
        check("R1 wrap", mem_addr, 32'h0);
        @(negedge clk);
        drive(1'b0, 1'b0, 2'b00, 1'b0, 32'h0, 16'h0, 32'h0);

        // R12: reset taken on the request's edge cancels the result.
        @(negedge clk);
        drive(1'b1, 1'b0, 2'b10, 1'b0, 32'h100, 16'h0, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        drive(1'b0, 1'b0, 2'b00, 1'b0, 32'h0, 16'h0, 32'h0);
        rst_n = 1'b1;
        #1;
        check("R12 cancelled load", {31'b0, load_valid}, 32'h0);
        @(negedge clk); #1;
        check("R12 still idle", {31'b0, load_valid}, 32'h0);

        finish_run();
    end

endmodule